// File: doc/BRIEF.md
# Quadrature Triangle-Carrier Dual PWM Core

This core drives two pulse-width-modulated outputs from a shared set of four triangular carriers. The carriers are 6-bit up/down counts from 0 to 63 and back. They run a quarter of a triangle period apart, so the set covers 0, 90, 180 and 270 degrees. Each channel compares its own 6-bit duty word against the carrier its selector names. Its output is high while the duty word is above the carrier value.

Channel phases, a 5-bit dead-time word and a 2-bit output-selector field arrive over a slow two-wire serial port, one bit per pulse of a shift clock. The core passes that shift clock and data line through a two-flop synchroniser into the main clock domain. It then shifts in one bit on each detected rising edge. The dead-time word and the output-selector field are not used here. They are exposed for a later gate-drive stage.

Top module: `quad_carrier_pwm`

## Requirements
- R1: While `rst_n` is low and after release until the first serial load, `pwm_a`, `pwm_b`, `dead_time` and `out_sel` are 0. All selector fields are 0.
- R2: The configuration register is 11 bits wide. Each accepted shift puts `cfg_sdata` at index 10 and moves every older bit one place toward index 0. After 11 shifts, the first bit sent is at index 0. The layout is: bits 4..0 form `dead_time`, bits 6..5 form the channel A selector, bits 8..7 form the channel B selector, and bits 10..9 form `out_sel`.
- R3: `cfg_sdata` is held steady while `cfg_sclk` is high. A low-to-high change of `cfg_sclk` then alters the register at the third `clk` rising edge after the change and at no earlier edge. Without a rising `cfg_sclk`, the register keeps its value, whatever `cfg_sdata` does.
- R4: Each carrier steps by exactly 1 per clock. It bounces between 0 and 63, so the period is 126 clocks. Call the triangle position p (0..125). The carrier value is p for p ≤ 63 and 126 − p otherwise. Carrier k (k = 0..3) sits at p = floor(k·126/4), that is 0, 31, 63 or 94, during reset. It advances one position at each clock edge after release.
- R5: Selector code 0, 1, 2 or 3 makes a channel compare against carrier 0, 1, 2 or 3 respectively.
- R6: Each PWM output is registered. After a clock edge, the output equals (duty word at that edge) > (selected carrier value held just before that edge), with the selector taken as held just before that edge.
- R7: Over any 126 consecutive clocks with a constant duty d and selector, the output is high for 0 clocks when d = 0 and for 2d − 1 clocks otherwise. For d = 13 that is 25 clocks. With d = 63 the output is low only after the carrier has been at 63.
- R8: The two channels select and compare independently. With both duties at 32 and selectors 0 and 2, the outputs are complementary on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low reset |
| cfg_sclk | input | 1 | Serial configuration shift clock (asynchronous) |
| cfg_sdata | input | 1 | Serial configuration data bit |
| duty_a | input | 6 | Channel A duty word |
| duty_b | input | 6 | Channel B duty word |
| pwm_a | output | 1 | Channel A raw PWM |
| pwm_b | output | 1 | Channel B raw PWM |
| dead_time | output | 5 | Dead-time word for the downstream stage |
| out_sel | output | 2 | Output-selector field for the downstream stage |

## Verification
A serial shift can land on the same clock as a PWM comparison whose carrier is turning around. In that clock a selector bit changes under a running channel, and the compare must pick up the new carrier exactly one edge after the register update. The bench provokes this by reloading selectors while both duty words are non-zero. It varies the gap between shift pulses so that updates fall at many carrier positions, turn points included. A free-running reference checks every clock against the triangle formula, using the selector the bench expects to be in force before each edge.

// File: rtl/qcp_pkg.sv
package qcp_pkg;
  localparam int CW     = 6;
  localparam int NPH    = 4;
  localparam int DT_W   = 5;
  localparam int SEL_W  = $clog2(NPH);
  localparam int NCH    = 2;

  localparam int MAXV   = (1 << CW) - 1;
  localparam int PERIOD = 2 * MAXV;

  localparam int SELA_LSB = DT_W;
  localparam int SELB_LSB = DT_W + SEL_W;
  localparam int OSEL_LSB = DT_W + 2 * SEL_W;
  localparam int CFG_LEN  = DT_W + 3 * SEL_W;

  typedef logic [CW-1:0]            carrier_t;
  typedef carrier_t [NPH-1:0]       carrier_bank_t;
  typedef logic [SEL_W-1:0]         sel_t;
  typedef logic [CFG_LEN-1:0]       cfg_t;

  // starting triangle position of phase copy k
  function automatic int phase_pos(input int k);
    return (k * PERIOD) / NPH;
  endfunction

  function automatic carrier_t tri_value(input int pos);
    if (pos <= MAXV) return carrier_t'(pos);
    return carrier_t'(PERIOD - pos);
  endfunction

  function automatic logic tri_rising(input int pos);
    return (pos < MAXV);
  endfunction

  function automatic carrier_t step_value(input carrier_t v, input logic up);
    return up ? carrier_t'(v + carrier_t'(1)) : carrier_t'(v - carrier_t'(1));
  endfunction

  function automatic logic step_dir(input carrier_t v, input logic up);
    if (up) return (v != carrier_t'(MAXV - 1));
    return (v == carrier_t'(1));
  endfunction

  function automatic logic pwm_level(input carrier_t duty, input carrier_t c);
    return (duty > c);
  endfunction
endpackage

// File: rtl/qcp_cfg_shift.sv
module qcp_cfg_shift
  import qcp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic sdata_i,
  output cfg_t cfg_o,
  output logic shift_rise_o
);
  logic [1:0] sclk_sync;
  logic       sclk_prev;
  logic [1:0] sdat_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sync <= '0;
      sclk_prev <= 1'b0;
      sdat_sync <= '0;
    end else begin
      sclk_sync <= {sclk_sync[0], sclk_i};
      sclk_prev <= sclk_sync[1];
      sdat_sync <= {sdat_sync[0], sdata_i};
    end
  end

  assign shift_rise_o = sclk_sync[1] & ~sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cfg_o <= '0;
    else if (shift_rise_o) cfg_o <= {sdat_sync[1], cfg_o[CFG_LEN-1:1]};
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_rise_o |=> $stable(cfg_o));

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_rise_o |=> (cfg_o[CFG_LEN-1] == $past(sdat_sync[1])) &&
                     (cfg_o[CFG_LEN-2:0] == $past(cfg_o[CFG_LEN-1:1])));

  p_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_rise_o |=> !shift_rise_o);
endmodule

// File: rtl/qcp_carrier.sv
module qcp_carrier
  import qcp_pkg::*;
#(
  parameter int PHASE = 0
) (
  input  logic     clk,
  input  logic     rst_n,
  output carrier_t value_o
);
  localparam int       INIT_POS = phase_pos(PHASE);
  localparam carrier_t INIT_VAL = tri_value(INIT_POS);
  localparam logic     INIT_UP  = tri_rising(INIT_POS);

  logic rising;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_o <= INIT_VAL;
      rising  <= INIT_UP;
    end else begin
      value_o <= step_value(value_o, rising);
      rising  <= step_dir(value_o, rising);
    end
  end

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((int'(value_o) - int'($past(value_o)) == 1) ||
              (int'(value_o) - int'($past(value_o)) == -1)));

  p_peak_turn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (value_o == carrier_t'(MAXV)) |=> (value_o == carrier_t'(MAXV - 1)));

  p_floor_turn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (value_o == carrier_t'(0)) |=> (value_o == carrier_t'(1)));
endmodule

// File: rtl/qcp_channel.sv
module qcp_channel
  import qcp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  carrier_bank_t bank_i,
  input  sel_t          sel_i,
  input  carrier_t      duty_i,
  output carrier_t      chosen_o,
  output logic          pwm_o
);
  assign chosen_o = bank_i[sel_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_o <= 1'b0;
    else        pwm_o <= pwm_level(duty_i, chosen_o);
  end

  p_zero_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_i == '0) |=> !pwm_o);

  p_peak_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chosen_o == carrier_t'(MAXV)) |=> !pwm_o);

  p_full_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((duty_i == carrier_t'(MAXV)) && (chosen_o != carrier_t'(MAXV))) |=> pwm_o);
endmodule

// File: rtl/quad_carrier_pwm.sv
module quad_carrier_pwm
  import qcp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_sclk,
  input  logic            cfg_sdata,
  input  logic [CW-1:0]   duty_a,
  input  logic [CW-1:0]   duty_b,
  output logic            pwm_a,
  output logic            pwm_b,
  output logic [DT_W-1:0] dead_time,
  output logic [SEL_W-1:0] out_sel
);
  cfg_t          cfg;
  logic          shift_rise;
  carrier_bank_t bank;
  carrier_t      duty_arr   [NCH];
  carrier_t      chosen_arr [NCH];
  logic [NCH-1:0] pwm_arr;

  qcp_cfg_shift u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .sclk_i       (cfg_sclk),
    .sdata_i      (cfg_sdata),
    .cfg_o        (cfg),
    .shift_rise_o (shift_rise)
  );

  for (genvar k = 0; k < NPH; k++) begin : g_carrier
    qcp_carrier #(.PHASE(k)) u_car (
      .clk     (clk),
      .rst_n   (rst_n),
      .value_o (bank[k])
    );
  end

  assign duty_arr[0] = duty_a;
  assign duty_arr[1] = duty_b;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    qcp_channel u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .bank_i   (bank),
      .sel_i    (cfg[SELA_LSB + ch*SEL_W +: SEL_W]),
      .duty_i   (duty_arr[ch]),
      .chosen_o (chosen_arr[ch]),
      .pwm_o    (pwm_arr[ch])
    );
  end

  assign pwm_a     = pwm_arr[0];
  assign pwm_b     = pwm_arr[1];
  assign dead_time = cfg[DT_W-1:0];
  assign out_sel   = cfg[OSEL_LSB +: SEL_W];

  if (NPH == 4) begin : g_quad_chk
    p_antiphase_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(bank[0]) + int'(bank[2]) == MAXV));
    p_antiphase_odd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(bank[1]) + int'(bank[3]) == MAXV));
  end

  p_sel_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[SELA_LSB +: SEL_W] == '0) |-> (chosen_arr[0] == bank[0]));

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!pwm_a && !pwm_b && (dead_time == '0) && (out_sel == '0)));
endmodule

// File: tb/test_quad_carrier_pwm.sv
module test_quad_carrier_pwm;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_sclk = 1'b0;
  logic       cfg_sdata = 1'b0;
  logic [5:0] duty_a = 6'd0;
  logic [5:0] duty_b = 6'd0;
  logic       pwm_a, pwm_b;
  logic [4:0] dead_time;
  logic [1:0] out_sel;

  quad_carrier_pwm i_quad_carrier_pwm (
    .clk(clk), .rst_n(rst_n), .cfg_sclk(cfg_sclk), .cfg_sdata(cfg_sdata),
    .duty_a(duty_a), .duty_b(duty_b), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .dead_time(dead_time), .out_sel(out_sel)
  );

  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  int edges    = 0;
  bit finished = 0;
  logic [10:0] exp_sr = '0;
  int offs [4] = '{0, 31, 63, 94};

  logic [5:0] prev_da = 0, prev_db = 0;
  logic [1:0] prev_sa = 0, prev_sb = 0;

  function automatic int exp_tri(input int p);
    int q = p % 126;
    return (q > 63) ? 126 - q : q;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) if (rst_n) edges++;

  // continuous reference for both channels
  always @(negedge clk) begin
    if (!finished) begin
      if (!rst_n) begin
        chk(pwm_a == 1'b0 && pwm_b == 1'b0, "R1 pwm in reset", {pwm_a, pwm_b}, 0);
      end else if (edges > 0) begin
        logic ea, eb;
        ea = int'(prev_da) > exp_tri(offs[prev_sa] + edges - 1);
        eb = int'(prev_db) > exp_tri(offs[prev_sb] + edges - 1);
        chk(pwm_a == ea, "R5/R6 pwm_a", pwm_a, ea);
        chk(pwm_b == eb, "R5/R6 pwm_b", pwm_b, eb);
      end
      prev_da = duty_a;  prev_db = duty_b;
      prev_sa = exp_sr[6:5];  prev_sb = exp_sr[8:7];
    end
  end

  task automatic shift_bit(input logic b, input int gap);
    @(posedge clk); #1;
    cfg_sdata = b; cfg_sclk = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk({out_sel, dead_time} == {exp_sr[10:9], exp_sr[4:0]}, "R3 no early update",
        {out_sel, dead_time}, {exp_sr[10:9], exp_sr[4:0]});
    @(posedge clk); #1;
    exp_sr = {b, exp_sr[10:1]};
    chk({out_sel, dead_time} == {exp_sr[10:9], exp_sr[4:0]}, "R2/R3 update at third edge",
        {out_sel, dead_time}, {exp_sr[10:9], exp_sr[4:0]});
    @(posedge clk); #1;
    cfg_sclk = 1'b0;
    repeat (3 + gap) @(posedge clk);
  endtask

  task automatic load_cfg(input logic [10:0] w, input int gapseed);
    for (int i = 0; i < 11; i++) shift_bit(w[i], (gapseed + i) % 5);
    #1;
    chk(dead_time == w[4:0], "R2 dead_time field", dead_time, w[4:0]);
    chk(out_sel == w[10:9], "R2 out_sel field", out_sel, w[10:9]);
  endtask

  task automatic set_duty(input logic [5:0] a, input logic [5:0] b);
    @(posedge clk); #1;
    duty_a = a; duty_b = b;
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk(dead_time == 0 && out_sel == 0, "R1 fields in reset", {out_sel, dead_time}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(dead_time == 0 && out_sel == 0, "R1 fields after release", {out_sel, dead_time}, 0);
  endtask

  task automatic t_count(input logic [5:0] d, input logic [1:0] s);
    int highs = 0;
    int want;
    load_cfg({2'b00, 2'b00, s, 5'b00000}, 0);
    set_duty(d, d);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 126; i++) begin
      @(negedge clk);
      if (pwm_a) highs++;
    end
    want = (d == 0) ? 0 : 2 * int'(d) - 1;
    chk(highs == want, "R7 highs per period", highs, want);
  endtask

  task automatic t_complement();
    load_cfg({2'b10, 2'b10, 2'b00, 5'b10101}, 2);
    set_duty(6'd32, 6'd32);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 126; i++) begin
      @(negedge clk);
      chk(pwm_a != pwm_b, "R8 complementary at 0/180", {pwm_a, pwm_b}, 1);
    end
  endtask

  task automatic t_hold();
    logic [6:0] snap;
    snap = {out_sel, dead_time};
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1;
      cfg_sdata = ~cfg_sdata;
    end
    repeat (4) @(negedge clk);
    chk({out_sel, dead_time} == snap, "R3 data toggle ignored", {out_sel, dead_time}, snap);
  endtask

  task automatic t_overlap();
    set_duty(6'd13, 6'd50);
    load_cfg({2'b11, 2'b01, 2'b11, 5'b00110}, 1);
    set_duty(6'd40, 6'd7);
    load_cfg({2'b01, 2'b10, 2'b01, 5'b11001}, 3);
    set_duty(6'd63, 6'd1);
    load_cfg({2'b00, 2'b11, 2'b10, 5'b01111}, 4);
    repeat (130) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_count(6'd0, 2'd0);
        t_count(6'd13, 2'd1);
        t_count(6'd63, 2'd2);
        t_count(6'd32, 2'd3);
        t_complement();
        t_hold();
        t_overlap();
      end
      begin
        repeat (60000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule